// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind a serial memory's bus front end during write transactions. The front end marks the start of a transaction and loads the starting word address. It then hands over each received data byte with a one-cycle strobe, and finally signals the stop condition. The engine holds the bytes in a small page buffer indexed by the low bits of a running word pointer. When the pointer passes the end of the page it wraps back to the page's first entry, so any surplus bytes overwrite the ones buffered earlier.

At the stop, the engine raises a busy flag and waits out a write-cycle time that is set by a parameter and counted in clock cycles. After that it walks the page buffer once, in ascending offset order. For every entry that actually received a byte, it issues a single array write request. While busy, the engine ignores everything the front end sends. A write-protect input blocks bytes at the moment they arrive. If nothing was buffered when the stop comes, no write cycle starts.

The controller is a three-state machine:
- `S_COLLECT` is the idle and gathering state.
- `S_HOLD` is the timed write cycle.
- `S_PROGRAM` is the buffer scan.

The named transitions are:
- `go`: from `S_COLLECT` to `S_HOLD`, taken on a stop when at least one byte is buffered.
- `hold_done`: from `S_HOLD` to `S_PROGRAM`, taken when the timer expires.
- `scan_end`: from `S_PROGRAM` back to `S_COLLECT`, taken after the last offset.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low and the page buffer holds no entries.
- R2: A byte accepted in `S_COLLECT` is stored at the current pointer offset, and the pointer's low 4 bits then increase by one.
- R3: The pointer offset (low 4 bits of the 11-bit word address) wraps from 15 to 0 while the upper 7 bits (the page base) stay fixed; a later byte to an already filled offset replaces the earlier one.
- R4: Only offsets that received a byte since the last transaction start are written; there is exactly one array write per such offset.
- R5: On a stop that finds at least one buffered byte, `busy_o` rises in the next cycle and stays high for exactly WR_CYCLES + 16 cycles; the array writes occur in the last 16 of those cycles.
- R6: A byte strobed while `wp_i` is high is not stored and does not move the pointer; a stop with no buffered byte starts no write cycle and `busy_o` stays low.
- R7: While `busy_o` is high, byte strobes, transaction starts, address loads and stops have no effect on buffered contents, pointer or commit outcome.
- R8: A transaction start in `S_COLLECT` discards every previously buffered byte but keeps the pointer.
- R9: Array writes go out in ascending offset order, with `arr_addr_o` = {page base, offset} and `arr_data_o` = the latest byte stored at that offset.
- R10: A byte strobed in the same cycle as the stop is buffered and included in the write cycle that stop starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start_i | input | 1 | Transaction start strobe; clears the buffered byte set |
| addr_load_i | input | 1 | Loads `addr_i` into the word pointer |
| addr_i | input | ADDR_W | Starting word address |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop strobe; starts the write cycle |
| wp_i | input | 1 | Write protect; high blocks incoming bytes |
| busy_o | output | 1 | High from the stop until the last array write |
| arr_we_o | output | 1 | Array write request |
| arr_addr_o | output | ADDR_W | Array write word address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
Two functions can land in the same cycle: the last byte's capture and the stop that decides whether a write cycle starts. A second pair is a byte capture and the buffer clear caused by a transaction start. The bench drives a data strobe together with the stop, both as the only byte of a transaction and as the final byte after others. It judges the outcome by the extra scoreboard entry for that byte and by the busy length. Strobes are also driven while the engine is busy; any write they cause shows up as an unexpected item or a changed pointer in the following transaction.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_HOLD    = 2'd1,
        S_PROGRAM = 2'd2
    } commit_state_e;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         ld_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         wr_i,
    input  logic [DATA_W-1:0]            data_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
    output logic [PAGE_BYTES-1:0]        mask_o,
    output logic [ADDR_W-1:0]            ptr_o,
    output logic [DATA_W-1:0]            rd_data_o
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;

    logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [ADDR_W-1:0]     ptr_q;
    logic [ADDR_W-1:0]     ptr_eff;
    logic [OFF_W-1:0]      off_eff;

    assign ptr_eff = ld_i ? addr_i : ptr_q;
    assign off_eff = ptr_eff[OFF_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_i) begin
            ptr_q <= {ptr_eff[ADDR_W-1:OFF_W], off_eff + OFF_W'(1)};
        end else if (ld_i) begin
            ptr_q <= addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (clr_i ? '0 : mask_q) |
                      (wr_i ? (PAGE_BYTES'(1) << off_eff) : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem_q[off_eff] <= data_i;
        end
    end

    assign mask_o    = mask_q;
    assign ptr_o     = ptr_q;
    assign rd_data_o = mem_q[rd_idx_i];

    // R2: each stored byte advances the offset by one
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ld_i) |=> (ptr_q[OFF_W-1:0] == $past(ptr_q[OFF_W-1:0]) + OFF_W'(1)));

    // R3: the page base never moves on a byte store
    assert_base_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ld_i) |=> (ptr_q[ADDR_W-1:OFF_W] == $past(ptr_q[ADDR_W-1:OFF_W])));

    // R4: without a store or clear the valid set is unchanged
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> $stable(mask_q));

    if (BASE_W < 1) begin : g_bad_width
        initial $error("page_buffer: ADDR_W must exceed the offset width");
    end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int LIMIT = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            else               cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign done_o = run_q && (cnt_q == LAST);

    // R5: the count never leaves the programmed window
    assert_timer_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= LAST));

    // R5: expiry ends the run
    assert_timer_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !run_q);
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
    import page_commit_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(PAGE_BYTES - 1);

    commit_state_e         state_q, state_d;
    logic [OFF_W-1:0]      scan_q;
    logic [PAGE_BYTES-1:0] buf_mask;
    logic [ADDR_W-1:0]     buf_ptr;
    logic [DATA_W-1:0]     buf_rd;
    logic                  collecting, accept, go, hold_done, scan_end, mask_clr;

    assign collecting = (state_q == S_COLLECT);
    assign accept     = collecting && byte_valid_i && !wp_i;
    assign go         = collecting && stop_i && ((|buf_mask) || accept);
    assign scan_end   = (state_q == S_PROGRAM) && (scan_q == LAST_IDX);
    assign mask_clr   = (collecting && txn_start_i) || scan_end;

    page_buffer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr_i(mask_clr),
        .ld_i(collecting && addr_load_i),
        .addr_i(addr_i),
        .wr_i(accept),
        .data_i(byte_data_i),
        .rd_idx_i(scan_q),
        .mask_o(buf_mask),
        .ptr_o(buf_ptr),
        .rd_data_o(buf_rd)
    );

    cycle_timer #(.LIMIT(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_i(go),
        .done_o(hold_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: if (go)        state_d = S_HOLD;
            S_HOLD:    if (hold_done) state_d = S_PROGRAM;
            S_PROGRAM: if (scan_end)  state_d = S_COLLECT;
            default:                  state_d = S_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_COLLECT;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= (state_q == S_PROGRAM) ? scan_q + OFF_W'(1) : '0;
        end
    end

    always_comb begin
        busy_o     = (state_q != S_COLLECT);
        arr_we_o   = (state_q == S_PROGRAM) && buf_mask[scan_q];
        arr_addr_o = {buf_ptr[ADDR_W-1:OFF_W], scan_q};
        arr_data_o = buf_rd;
    end

    // R5: a stop with buffered data makes the engine busy next cycle
    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && stop_i && (|buf_mask)) |=> busy_o);

    // R5: the scan of the last offset releases busy
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end |=> !busy_o);

    // R6: an empty buffer at stop starts nothing
    assert_no_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && stop_i && (buf_mask == '0) && (!byte_valid_i || wp_i)) |=> !busy_o);

    // R7: contents and pointer are frozen while busy
    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !scan_end) |=> ($stable(buf_mask) && $stable(buf_ptr)));
endmodule

// File: tb/tb_page_commit_engine.sv
module tb_page_commit_engine;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int PB = 16;
    localparam int WR = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_start_i = 0, addr_load_i = 0, byte_valid_i = 0, stop_i = 0, wp_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] byte_data_i = '0;
    logic          busy_o, arr_we_o;
    logic [AW-1:0] arr_addr_o;
    logic [DW-1:0] arr_data_o;

    always #4 clk = ~clk;

    page_commit_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start_i), .addr_load_i(addr_load_i),
        .addr_i(addr_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .stop_i(stop_i), .wp_i(wp_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
        .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference model, built from the requirements
    logic [AW-1:0] m_ptr = '0;
    logic [DW-1:0] m_buf [PB];
    logic [PB-1:0] m_mask = '0;
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && arr_we_o) begin
            if (q_addr.size() == 0) begin
                check(0, "R4", "unexpected write addr", int'(arr_addr_o), 0);
            end else begin
                automatic logic [AW-1:0] ea = q_addr.pop_front();
                automatic logic [DW-1:0] ed = q_data.pop_front();
                automatic string tg = q_tag.pop_front();
                check(arr_addr_o == ea, tg, "write addr", int'(arr_addr_o), int'(ea));
                check(arr_data_o == ed, tg, "write data", int'(arr_data_o), int'(ed));
            end
        end
    end

    task automatic t_start();
        txn_start_i = 1; m_mask = '0;
        @(posedge clk); #1 txn_start_i = 0;
    endtask

    task automatic t_addr(input logic [AW-1:0] a);
        addr_load_i = 1; addr_i = a; m_ptr = a;
        @(posedge clk); #1 addr_load_i = 0;
    endtask

    task automatic model_byte(input logic [DW-1:0] d);
        if (!wp_i) begin
            m_buf[m_ptr[3:0]] = d;
            m_mask[m_ptr[3:0]] = 1'b1;
            m_ptr = {m_ptr[AW-1:4], m_ptr[3:0] + 4'd1};
        end
    endtask

    task automatic t_byte(input logic [DW-1:0] d);
        byte_valid_i = 1; byte_data_i = d; model_byte(d);
        @(posedge clk); #1 byte_valid_i = 0;
    endtask

    // stop, optionally with a final byte in the same cycle and pokes while busy
    task automatic t_stop(input string tg, input bit with_byte, input logic [DW-1:0] d,
                          input bit poke);
        int exp_busy, n;
        stop_i = 1;
        if (with_byte) begin byte_valid_i = 1; byte_data_i = d; model_byte(d); end
        if (m_mask != '0) begin
            for (int i = 0; i < PB; i++) if (m_mask[i]) begin
                q_addr.push_back({m_ptr[AW-1:4], 4'(i)});
                q_data.push_back(m_buf[i]);
                q_tag.push_back(tg);
            end
            exp_busy = WR + PB;
            m_mask = '0;
        end else begin
            exp_busy = 0;
        end
        @(posedge clk); #1 stop_i = 0; byte_valid_i = 0;
        n = 0;
        forever begin
            @(negedge clk);
            byte_valid_i = 0; txn_start_i = 0; addr_load_i = 0; stop_i = 0;
            if (!busy_o) break;
            n++;
            if (poke) begin
                if (n == 3)  begin byte_valid_i = 1; byte_data_i = 8'hEE; end
                if (n == 5)  txn_start_i = 1;
                if (n == 7)  begin addr_load_i = 1; addr_i = 11'h555; end
                if (n == 9)  stop_i = 1;
                if (n == 30) begin byte_valid_i = 1; byte_data_i = 8'hDD; end
            end
        end
        check(n == exp_busy, tg, "busy length", n, exp_busy);
        check(q_addr.size() == 0, tg, "missing writes", q_addr.size(), 0);
        q_addr.delete(); q_data.delete(); q_tag.delete();
        @(posedge clk); #1;
    endtask

    initial begin
        #1600000;
        check(0, "R5", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy_o == 0, "R1", "busy in reset", busy_o, 0);
        check(arr_we_o == 0, "R1", "write in reset", arr_we_o, 0);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R1: empty buffer after reset, stop starts nothing
        t_stop("R1", 0, 0, 0);

        // R9 R4: single byte
        t_start(); t_addr(11'h123); t_byte(8'hA5);
        t_stop("R9", 0, 0, 0);

        // R2: full page
        t_start(); t_addr(11'h040);
        for (int i = 0; i < 16; i++) t_byte(8'(8'h10 + i));
        t_stop("R2", 0, 0, 0);

        // R3: wrap with overwrite, 19 bytes from offset 12
        t_start(); t_addr(11'h07C);
        for (int i = 0; i < 19; i++) t_byte(8'(8'h80 + i));
        t_stop("R3", 0, 0, 0);

        // R4: partial page, scattered by two address loads
        t_start(); t_addr(11'h1A2); t_byte(8'h11); t_byte(8'h22);
        t_addr(11'h1A9); t_byte(8'h33);
        t_stop("R4", 0, 0, 0);

        // R6: protected bytes are dropped and no cycle starts
        t_start(); t_addr(11'h200);
        wp_i = 1; t_byte(8'h66); t_byte(8'h67); wp_i = 0;
        t_stop("R6", 0, 0, 0);
        // R6: pointer not moved by protected bytes
        t_start(); t_byte(8'h68);
        t_stop("R6", 0, 0, 0);

        // R8: start discards earlier bytes, pointer kept
        t_start(); t_addr(11'h300); t_byte(8'h01); t_byte(8'h02);
        t_start(); t_byte(8'h03);
        t_stop("R8", 0, 0, 0);

        // R7: strobes while busy are ignored
        t_start(); t_addr(11'h4F0); t_byte(8'h44);
        t_stop("R7", 0, 0, 1);
        t_start(); t_byte(8'h45);
        t_stop("R7", 0, 0, 0);

        // R10: byte coincident with stop, alone and after others
        t_start(); t_addr(11'h610);
        t_stop("R10", 1, 8'h5A, 0);
        t_start(); t_addr(11'h62E); t_byte(8'h71);
        t_stop("R10", 1, 8'h72, 0);

        finish_run();
    end
endmodule